// File: doc/BRIEF.md
# Page Write Timer with Toggle Polling

This block sits behind a bus interface and gathers single-byte writes into a page buffer. The first accepted write opens a page, identified by the address bits above the in-page offset. Every further write to that page lands in the buffer and restarts a load window. When the window runs out with no further write, the buffered bytes are committed to the storage array together. The block then models a fixed internal programming time, measured in clock cycles.

While programming runs, the array cannot be reached. Writes are dropped. A read returns a status byte whose bit 6 flips on every read, so a host can poll for completion instead of waiting out the worst-case time. Once programming ends, reads return array contents again and the block is free to open a new page. All durations and sizes are parameters.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset `busy` and `rd_valid` are low, and every array location reads as 0x00.
- R2: Outside the programming phase, a read pulse on `rd_en` returns the array byte at `rd_addr` on `rd_data`, with `rd_valid` high, one clock after the pulse. `rd_valid` is low in cycles with no read one clock earlier.
- R3: A write accepted while the block is idle opens the page given by `wr_addr[ADDR_W-1:PAGE_W]`, and `busy` is high from the next clock.
- R4: Each accepted write restarts the load window. The page is committed only after LOAD_CYC clocks pass with no accepted write. A write in the window's final cycle wins over expiry.
- R5: While a page is open, a write whose bits above the low PAGE_W address bits differ from the open page is ignored. It changes no array byte and does not restart the window.
- R6: Only offsets written during the load phase are committed, and the rest of the page keeps its old contents. When an offset is written twice, the later byte is the one committed.
- R7: Programming lasts exactly PROG_CYC clocks. `busy` falls exactly LOAD_CYC+PROG_CYC clocks after the clock that accepted the last write of the page.
- R8: Writes presented during programming are ignored and are not buffered. `busy` is low once programming ends, and the targeted byte keeps its old value.
- R9: A read during programming returns a status byte with every bit 0 except bit 6. Bit 6 is 1 on the first such read and inverts on each later read.
- R10: After programming ends, reads return the committed array data, and repeated reads of one address give the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write pulse |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read request pulse |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Array byte or status byte |
| rd_valid | output | 1 | `rd_data` holds the answer to the previous cycle's read |
| busy | output | 1 | High from the first buffered byte until programming ends |

## Verification
Several properties are checked on every clock:
- the status byte carries nothing outside bit 6, and its toggle bit starts at 1 and flips on each polled read;
- no write is accepted during programming;
- the open page stays fixed while bytes are buffered, and a commit never happens with an empty mask;
- the programming counter stays in range.

Only the bench's scenarios can show the rest. These are the exact busy length after the last write, the window restart, the contents the array holds after a commit, the bytes that stayed untouched, and the dropped writes.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int BYTE_W     = 8;
  localparam int TOGGLE_BIT = 6;

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_PROG} phase_t;

  // Status byte seen by a poller: only the toggle position may be set.
  function automatic logic [BYTE_W-1:0] status_byte(input logic tog);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[TOGGLE_BIT] = tog;
    return s;
  endfunction
endpackage

// File: rtl/pwt_sequencer.sv
module pwt_sequencer
  import pwt_pkg::*;
#(
  parameter int LOAD_CYC = 8,
  parameter int PROG_CYC = 24
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  logic   page_hit,
  input  logic   rd_en,
  output logic   accept,
  output logic   commit,
  output phase_t phase,
  output logic   tog
);
  localparam int LW = $clog2(LOAD_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1);

  logic [LW-1:0] load_cnt;
  logic [PW-1:0] prog_cnt;

  // A write is taken when idle, or when it targets the page already open.
  assign accept = wr_en && (phase == PH_IDLE || (phase == PH_LOAD && page_hit));
  // Window expiry, unless a fresh write restarts it in the same cycle.
  assign commit = (phase == PH_LOAD) && !accept && (load_cnt == LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      load_cnt <= '0;
      prog_cnt <= '0;
      tog      <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE, PH_LOAD: begin
          if (accept) begin
            phase    <= PH_LOAD;
            load_cnt <= LW'(LOAD_CYC);
          end else if (commit) begin
            phase    <= PH_PROG;
            load_cnt <= '0;
            prog_cnt <= PW'(PROG_CYC);
            tog      <= 1'b1;
          end else if (phase == PH_LOAD) begin
            load_cnt <= load_cnt - LW'(1);
          end
        end
        default: begin
          if (rd_en) tog <= ~tog;
          if (prog_cnt == PW'(1)) begin
            phase    <= PH_IDLE;
            prog_cnt <= '0;
          end else begin
            prog_cnt <= prog_cnt - PW'(1);
          end
        end
      endcase
    end
  end

  AST_TOG_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_PROG) |-> tog);  // R9
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PROG && rd_en) |=> (tog != $past(tog)));  // R9
  AST_PROG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    prog_cnt <= PW'(PROG_CYC));  // R7
endmodule

// File: rtl/pwt_page_buf.sv
module pwt_page_buf
  import pwt_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 7
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   accept,
  input  logic                                   commit,
  input  logic [ADDR_W-1:0]                      wr_addr,
  input  logic [BYTE_W-1:0]                      wr_data,
  output logic                                   page_hit,
  output logic [ADDR_W-PAGE_W-1:0]               open_page,
  output logic [(1<<PAGE_W)-1:0][BYTE_W-1:0]     buf_data,
  output logic [(1<<PAGE_W)-1:0]                 mask
);
  localparam int TAG_W = ADDR_W - PAGE_W;

  function automatic logic [TAG_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_W];
  endfunction
  function automatic logic [PAGE_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[PAGE_W-1:0];
  endfunction

  assign page_hit = (page_of(wr_addr) == open_page);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= '0;
      open_page <= '0;
    end else if (accept) begin
      open_page                   <= page_of(wr_addr);
      mask[offset_of(wr_addr)]     <= 1'b1;
    end else if (commit) begin
      mask <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) buf_data[offset_of(wr_addr)] <= wr_data;
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask && !commit) |=> $stable(open_page));  // R5
endmodule

// File: rtl/pwt_array.sv
module pwt_array
  import pwt_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 7
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               commit,
  input  logic [ADDR_W-PAGE_W-1:0]           page,
  input  logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] buf_data,
  input  logic [(1<<PAGE_W)-1:0]             mask,
  input  logic [ADDR_W-1:0]                  rd_addr,
  output logic [BYTE_W-1:0]                  rd_word
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (mask[i]) mem[{page, PAGE_W'(i)}] <= buf_data[i];
    end
  end

  assign rd_word = mem[rd_addr];

  AST_COMMIT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (|mask));  // R6
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwt_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int PAGE_W   = 7,
  parameter int LOAD_CYC = 8,
  parameter int PROG_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy
);
  localparam int TAG_W = ADDR_W - PAGE_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  // Named internal events, brought out for the assertions.
  logic                                accept;
  logic                                commit;
  logic                                page_hit;
  logic                                tog;
  logic                                in_prog;
  phase_t                              phase;
  logic [TAG_W-1:0]                    open_page;
  logic [PAGE_BYTES-1:0][BYTE_W-1:0]   buf_data;
  logic [PAGE_BYTES-1:0]               mask;
  logic [BYTE_W-1:0]                   rd_word;

  pwt_sequencer #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .page_hit(page_hit),
    .rd_en(rd_en), .accept(accept), .commit(commit), .phase(phase), .tog(tog)
  );

  pwt_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .accept(accept), .commit(commit),
    .wr_addr(wr_addr), .wr_data(wr_data), .page_hit(page_hit),
    .open_page(open_page), .buf_data(buf_data), .mask(mask)
  );

  pwt_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .page(open_page),
    .buf_data(buf_data), .mask(mask), .rd_addr(rd_addr), .rd_word(rd_word)
  );

  assign in_prog = (phase == PH_PROG);
  assign busy    = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= in_prog ? status_byte(tog) : rd_word;
    end
  end

  AST_NO_WR_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    in_prog |-> !accept);  // R8
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);  // R3
  AST_STATUS_ONLY_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(in_prog)) |-> ((rd_data & ~8'h40) == 8'h00));  // R9
endmodule

// File: tb/tb_page_write_ctrl.sv
`timescale 1ns/1ps
module tb_page_write_ctrl;
  localparam int AW = 9;
  localparam int PW = 7;
  localparam int LC = 8;
  localparam int PC = 24;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_WAIT = 2'd2;
  localparam int NV = 15;
  // {op, address, data-or-expected}
  localparam logic [18:0] VEC [NV] = '{
    {OP_W, 9'h005, 8'hA1}, {OP_W, 9'h07F, 8'h5C}, {OP_W, 9'h005, 8'hB2},
    {OP_W, 9'h085, 8'hEE}, {OP_WAIT, 9'h000, 8'h00},
    {OP_R, 9'h005, 8'hB2}, {OP_R, 9'h07F, 8'h5C}, {OP_R, 9'h006, 8'h00},
    {OP_R, 9'h085, 8'h00}, {OP_W, 9'h100, 8'h11}, {OP_W, 9'h1A3, 8'h22},
    {OP_WAIT, 9'h000, 8'h00}, {OP_R, 9'h100, 8'h11}, {OP_R, 9'h1A3, 8'h00},
    {OP_R, 9'h101, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic          busy;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  page_write_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .LOAD_CYC(LC), .PROG_CYC(PC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       v;
    int         n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 busy", busy, 0);
    check("R1 rd_valid", rd_valid, 0);
    do_read(9'h1FF, d, v);
    check("R1 array zero", d, 8'h00);
    check("R2 rd_valid on read", v, 1);
    @(negedge clk);
    check("R2 rd_valid idle", rd_valid, 0);

    // Vector table: R2 R5 R6
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][18:17])
        OP_W:    do_write(VEC[i][16:8], VEC[i][7:0]);
        OP_WAIT: count_busy(n);
        default: begin
          do_read(VEC[i][16:8], d, v);
          check($sformatf("R2/R5/R6 vector %0d", i), {v, d}, {1'b1, VEC[i][7:0]});
        end
      endcase
    end

    // R3, R7: busy timing for one byte
    do_write(9'h0C0, 8'h33);
    check("R3 busy after write", busy, 1);
    count_busy(n);
    check("R7 busy length", n, LC + PC);
    do_read(9'h0C0, d, v);
    check("R7 committed byte", d, 8'h33);

    // R4: restart of the load window
    do_write(9'h140, 8'h44);
    repeat (LC - 3) @(negedge clk);
    check("R4 still loading", busy, 1);
    do_write(9'h141, 8'h55);
    count_busy(n);
    check("R4 busy from second write", n, LC + PC);
    do_read(9'h141, d, v);
    check("R4 second byte", d, 8'h55);
    do_read(9'h140, d, v);
    check("R4 first byte", d, 8'h44);

    // R9, R8, R10: polling during programming
    do_write(9'h1F0, 8'h3C);
    repeat (LC) @(negedge clk);
    check("R9 in programming", busy, 1);
    do_read(9'h1F0, d, v);
    check("R9 first poll", d, 8'h40);
    do_read(9'h1F0, d, v);
    check("R9 second poll", d, 8'h00);
    do_read(9'h1F0, d, v);
    check("R9 third poll", d, 8'h40);
    do_write(9'h00A, 8'h77);
    count_busy(n);
    @(negedge clk);
    check("R8 idle after programming", busy, 0);
    do_read(9'h00A, d, v);
    check("R8 write dropped", d, 8'h00);
    do_read(9'h1F0, d, v);
    check("R10 data after programming", d, 8'h3C);
    do_read(9'h1F0, d, v);
    check("R10 no toggle", d, 8'h3C);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule